// File: doc/BRIEF.md
# Multiple-Register Transfer Address Sequencer

This block walks through a load-multiple or store-multiple operation for a 32-bit core with sixteen general registers. When start is pulsed, it captures the base value, a 16-bit register list and the operation flags: direction of transfer, up/down, pre/post step, writeback, and the status/user-bank bit. It then issues one word-aligned bus access for each selected register. Every walk climbs from the lowest address to the highest, and registers are visited from the lowest index to the highest. A descending operation is handled by first computing the lowest address it will touch. After that, it runs the same upward walk as an ascending one.

The bus side is valid/ready. The block raises `bus_valid_o` and holds the address, the register index and the direction steady until it samples `bus_ready_i` high on a clock edge. That edge is the handshake. On the handshake the block also samples `bus_abort_i`. The far side may hold ready low for any number of cycles. The block has no other flow control. The register file, decode, memory and abort recovery lie outside the block. The block reports only the outcome: a one-cycle done pulse that carries the writeback value, a flag that says whether every access finished without abort, a user-bank request that is held for the whole operation, and pulses for loading the program counter and the status word.

Top module: `mxfer_seq`

## Requirements
- R1: Each set bit of the list causes exactly one bus access. Accesses are issued in ascending register index (bit 0 first, bit 15 last), and `bus_reg_o` carries the index.
- R2: Successive access addresses rise by 4. Bits [1:0] of `bus_addr_o` are always 0.
- R3: With up=0, the lowest address is base minus 4 times the number of set bits. The address is stepped by 4 before an access when the pre flag equals the up flag, and after the access otherwise.
- R4: At done, `wb_en_o` is high only when writeback was requested and the base index is not 15. `wb_val_o` is base+4n for up and base-4n for down.
- R5: When the base index is 15, the base value used is `pc_stat_i` + 8.
- R6: `user_bank_o` stays high from the cycle after start through done in two cases: a store (is_load=0) with S=1, or a load that does not list register 15. Otherwise it stays low.
- R7: The handshake that loads register 15 asserts `pc_load_o`. It also asserts `psr_load_o` when S=1. Neither pulses at any other time.
- R8: An abort on any handshake clears `all_ok_o` at done. The remaining accesses are still issued.
- R9: An empty list issues no access. Done rises in the cycle after start, and writeback still applies.
- R10: While valid is high and ready is low, the address, the register index and the direction stay unchanged in the next cycle.
- R11: After reset the block is idle: busy, valid and done are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| reg_list_i | input | 16 | Register selection mask |
| base_idx_i | input | 4 | Index of the base register |
| base_val_i | input | 32 | Base register contents (index not 15) |
| pc_stat_i | input | 32 | Program counter combined with status bits |
| is_load_i | input | 1 | 1 = load from memory, 0 = store |
| up_i | input | 1 | 1 = ascending, 0 = descending |
| pre_i | input | 1 | Pre-step flag |
| wb_i | input | 1 | Writeback requested |
| s_bit_i | input | 1 | Status/user-bank flag |
| busy_o | output | 1 | Operation in progress |
| bus_valid_o | output | 1 | Access request valid |
| bus_ready_i | input | 1 | Access accepted |
| bus_abort_i | input | 1 | Access aborted (sampled with ready) |
| bus_addr_o | output | 32 | Word-aligned access address |
| bus_write_o | output | 1 | 1 = memory write (store) |
| bus_reg_o | output | 4 | Register index for this access |
| user_bank_o | output | 1 | Use the user register bank |
| pc_load_o | output | 1 | Loaded word goes to the program counter |
| psr_load_o | output | 1 | Loaded word also goes to the status register |
| done_o | output | 1 | One-cycle completion pulse |
| all_ok_o | output | 1 | No access aborted (valid with done) |
| wb_en_o | output | 1 | Write `wb_val_o` into the base register |
| wb_val_o | output | 32 | Writeback value |

## Verification
The hardest case to reach from the ports is an abort in the middle of an operation while ready is also stalling. In that case the block must keep the stalled request steady, record the abort, and still finish the remaining accesses. The bench drives a repeating ready pattern with stall cycles during every vector, and it raises abort on exactly one chosen handshake of a descending load. Register 15 is covered twice: once as a listed register in a load with S=1, and once as the base. An empty list is run separately to catch the single-cycle completion.

// File: rtl/mxfer_pkg.sv
package mxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mx_state_e;

  typedef struct packed {
    logic is_load;
    logic step_first;
    logic s_bit;
    logic wb_ok;
    logic use_user;
  } mx_ctl_t;
endpackage

// File: rtl/mxfer_popcnt.sv
module mxfer_popcnt #(
  parameter int W = 16
) (
  input  logic [W-1:0]             vec_i,
  output logic [$clog2(W+1)-1:0]   cnt_o
);
  localparam int CW = $clog2(W+1);

  logic [CW-1:0] partial [W+1];

  assign partial[0] = '0;
  for (genvar g = 0; g < W; g++) begin : g_sum
    assign partial[g+1] = partial[g] + CW'(vec_i[g]);
  end
  assign cnt_o = partial[W];
endmodule

// File: rtl/mxfer_lowbit.sv
module mxfer_lowbit #(
  parameter int W = 16
) (
  input  logic [W-1:0]         vec_i,
  output logic                 any_o,
  output logic [$clog2(W)-1:0] idx_o
);
  localparam int IW = $clog2(W);

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/mxfer_seq.sv
module mxfer_seq
  import mxfer_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic [NREG-1:0]         reg_list_i,
  input  logic [$clog2(NREG)-1:0] base_idx_i,
  input  logic [XLEN-1:0]         base_val_i,
  input  logic [XLEN-1:0]         pc_stat_i,
  input  logic                    is_load_i,
  input  logic                    up_i,
  input  logic                    pre_i,
  input  logic                    wb_i,
  input  logic                    s_bit_i,
  output logic                    busy_o,
  output logic                    bus_valid_o,
  input  logic                    bus_ready_i,
  input  logic                    bus_abort_i,
  output logic [XLEN-1:0]         bus_addr_o,
  output logic                    bus_write_o,
  output logic [$clog2(NREG)-1:0] bus_reg_o,
  output logic                    user_bank_o,
  output logic                    pc_load_o,
  output logic                    psr_load_o,
  output logic                    done_o,
  output logic                    all_ok_o,
  output logic                    wb_en_o,
  output logic [XLEN-1:0]         wb_val_o
);
  localparam int IDXW     = $clog2(NREG);
  localparam int CNTW     = $clog2(NREG + 1);
  localparam int SHIFT    = $clog2(WORD_BYTES);
  localparam logic [IDXW-1:0] PC_IDX = IDXW'(NREG - 1);
  localparam logic [XLEN-1:0] STEP   = XLEN'(WORD_BYTES);
  localparam logic [XLEN-1:0] AHEAD  = XLEN'(2 * WORD_BYTES);

  mx_state_e         state_q;
  logic [NREG-1:0]   rem_q;
  logic [XLEN-1:0]   addr_q;
  logic [XLEN-1:0]   wbv_q;
  mx_ctl_t           ctl_q;
  logic              ok_q;

  // Count of selected registers, taken in the start cycle
  logic [CNTW-1:0]   sel_cnt;
  mxfer_popcnt #(.W(NREG)) u_cnt (
    .vec_i (reg_list_i),
    .cnt_o (sel_cnt)
  );

  // Next register to visit
  logic              rem_any;
  logic [IDXW-1:0]   rem_idx;
  mxfer_lowbit #(.W(NREG)) u_low (
    .vec_i (rem_q),
    .any_o (rem_any),
    .idx_o (rem_idx)
  );

  // Start-cycle arithmetic
  logic [XLEN-1:0] base_eff;
  logic [XLEN-1:0] span;
  logic [XLEN-1:0] low_addr;
  logic [XLEN-1:0] high_addr;
  assign base_eff  = (base_idx_i == PC_IDX) ? pc_stat_i + AHEAD : base_val_i;
  assign span      = XLEN'(sel_cnt) << SHIFT;
  assign low_addr  = base_eff - span;
  assign high_addr = base_eff + span;

  logic accept;
  logic hs;
  logic [NREG-1:0] rem_next;
  assign accept   = start_i && (state_q == ST_IDLE);
  assign hs       = bus_valid_o && bus_ready_i;
  assign rem_next = rem_q & ~(NREG'(1) << rem_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      addr_q  <= '0;
      wbv_q   <= '0;
      ctl_q   <= '0;
      ok_q    <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            rem_q            <= reg_list_i;
            addr_q           <= up_i ? base_eff : low_addr;
            wbv_q            <= up_i ? high_addr : low_addr;
            ctl_q.is_load    <= is_load_i;
            ctl_q.step_first <= (pre_i == up_i);
            ctl_q.s_bit      <= s_bit_i;
            ctl_q.wb_ok      <= wb_i && (base_idx_i != PC_IDX);
            ctl_q.use_user   <= (!is_load_i && s_bit_i) ||
                                (is_load_i && !reg_list_i[NREG-1]);
            ok_q             <= 1'b1;
            state_q          <= (reg_list_i == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (hs) begin
            rem_q  <= rem_next;
            addr_q <= addr_q + STEP;
            ok_q   <= ok_q && !bus_abort_i;
            if (rem_next == '0) state_q <= ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [XLEN-1:0] acc_addr;
  assign acc_addr = ctl_q.step_first ? addr_q + STEP : addr_q;

  assign busy_o      = (state_q != ST_IDLE);
  assign bus_valid_o = (state_q == ST_RUN) && rem_any;
  assign bus_addr_o  = {acc_addr[XLEN-1:SHIFT], {SHIFT{1'b0}}};
  assign bus_write_o = !ctl_q.is_load;
  assign bus_reg_o   = rem_idx;
  assign user_bank_o = busy_o && ctl_q.use_user;
  assign pc_load_o   = hs && ctl_q.is_load && (rem_idx == PC_IDX);
  assign psr_load_o  = pc_load_o && ctl_q.s_bit;
  assign done_o      = (state_q == ST_FIN);
  assign all_ok_o    = ok_q;
  assign wb_en_o     = done_o && ctl_q.wb_ok;
  assign wb_val_o    = wbv_q;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid_o && !bus_ready_i) |=>
      (bus_valid_o && $stable(bus_addr_o) && $stable(bus_reg_o) && $stable(bus_write_o)));

  // R1
  reg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (!bus_valid_o || (bus_reg_o > $past(bus_reg_o))));

  // R9
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (reg_list_i == '0)) |=> done_o);

  // R6
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> $stable(user_bank_o));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (rem_next != '0)) |=> (bus_addr_o == $past(bus_addr_o) + STEP));

  // R7
  pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (bus_ready_i && !bus_write_o));
endmodule

// File: tb/tb_mxfer_seq.sv
module tb_mxfer_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic [15:0] list;
    logic        up;
    logic        pre;
    logic        load;
    logic        s;
    logic        wb;
    logic [3:0]  bidx;
    logic [31:0] first;
    logic [31:0] wbv;
    logic        wben;
    logic        user;
  } vec_t;

  // base_val = 0x1000, pc_stat = 0x2000 for all vectors
  localparam vec_t VECS [NV] = '{
    '{16'h000F, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  32'h1000, 32'h1010, 1'b1, 1'b0},
    '{16'h000F, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2,  32'h1004, 32'h1010, 1'b1, 1'b0},
    '{16'h8005, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4'd3,  32'h0FF4, 32'h0FF4, 1'b1, 1'b0},
    '{16'h00F0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1,  32'h0FF4, 32'h0FF0, 1'b1, 1'b1},
    '{16'h0101, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd4,  32'h1000, 32'h1008, 1'b0, 1'b1},
    '{16'h0003, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd15, 32'h2008, 32'h2010, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] reg_list_i = '0;
  logic [3:0]  base_idx_i = '0;
  logic [31:0] base_val_i = 32'h1000;
  logic [31:0] pc_stat_i = 32'h2000;
  logic        is_load_i = 1'b0, up_i = 1'b1, pre_i = 1'b0, wb_i = 1'b0, s_bit_i = 1'b0;
  logic        busy_o, bus_valid_o, bus_write_o, user_bank_o, pc_load_o, psr_load_o;
  logic        done_o, all_ok_o, wb_en_o;
  logic        bus_ready_i = 1'b0, bus_abort_i = 1'b0;
  logic [31:0] bus_addr_o, wb_val_o;
  logic [3:0]  bus_reg_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mxfer_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reg_list_i(reg_list_i),
    .base_idx_i(base_idx_i), .base_val_i(base_val_i), .pc_stat_i(pc_stat_i),
    .is_load_i(is_load_i), .up_i(up_i), .pre_i(pre_i), .wb_i(wb_i), .s_bit_i(s_bit_i),
    .busy_o(busy_o), .bus_valid_o(bus_valid_o), .bus_ready_i(bus_ready_i),
    .bus_abort_i(bus_abort_i), .bus_addr_o(bus_addr_o), .bus_write_o(bus_write_o),
    .bus_reg_o(bus_reg_o), .user_bank_o(user_bank_o), .pc_load_o(pc_load_o),
    .psr_load_o(psr_load_o), .done_o(done_o), .all_ok_o(all_ok_o),
    .wb_en_o(wb_en_o), .wb_val_o(wb_val_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nth_set(input logic [15:0] l, input int k);
    int seen = 0;
    for (int i = 0; i < 16; i++) begin
      if (l[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  function automatic int pop(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(l[i]);
    return c;
  endfunction

  // Runs one operation; abort_at < 0 means no abort
  task automatic run_op(input vec_t v, input int abort_at, input logic exp_ok);
    int k = 0;
    int cyc = 0;
    logic stalled = 1'b0;
    logic [31:0] st_addr = '0;
    logic [3:0]  st_reg = '0;
    bit finished = 0;
    @(negedge clk);
    reg_list_i = v.list; up_i = v.up; pre_i = v.pre; is_load_i = v.load;
    s_bit_i = v.s; wb_i = v.wb; base_idx_i = v.bidx; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!finished) begin
      bus_ready_i = (cyc % 3) != 1;
      bus_abort_i = (k == abort_at) && bus_ready_i;
      #1;
      if (stalled) begin
        // R10 request held across a stall
        chk("R10 addr", bus_addr_o, st_addr);
        chk("R10 reg", {28'd0, bus_reg_o}, {28'd0, st_reg});
      end
      stalled = 1'b0;
      if (done_o) begin
        chk("R1 count", k, pop(v.list));
        chk("R4 wb_en", {31'd0, wb_en_o}, {31'd0, v.wben});
        if (v.wben) chk("R4 wb_val", wb_val_o, v.wbv);
        chk("R8 all_ok", {31'd0, all_ok_o}, {31'd0, exp_ok});
        chk("R6 user bank", {31'd0, user_bank_o}, {31'd0, v.user});
        finished = 1;
      end else if (bus_valid_o) begin
        if (k == 0) chk("R6 user bank", {31'd0, user_bank_o}, {31'd0, v.user});
        if (bus_ready_i) begin
          chk("R1 reg", {28'd0, bus_reg_o}, nth_set(v.list, k));
          // R2 R3 R5 address of k-th access
          chk("R2/R3/R5 addr", bus_addr_o, v.first + 32'(4 * k));
          chk("R7 pc_load", {31'd0, pc_load_o},
              {31'd0, v.load && (bus_reg_o == 4'd15)});
          chk("R7 psr_load", {31'd0, psr_load_o},
              {31'd0, v.load && v.s && (bus_reg_o == 4'd15)});
          k++;
        end else begin
          stalled = 1'b1;
          st_addr = bus_addr_o;
          st_reg  = bus_reg_o;
        end
      end
      cyc++;
      @(negedge clk);
    end
    bus_ready_i = 1'b0;
    bus_abort_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 busy", {31'd0, busy_o}, 32'd0);
    chk("R11 valid", {31'd0, bus_valid_o}, 32'd0);
    chk("R11 done", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i], (i == 3) ? 1 : -1, (i == 3) ? 1'b0 : 1'b1);  // R8 abort on vector 3
    end

    // R9 empty list: done the cycle after start, writeback still applied
    @(negedge clk);
    reg_list_i = '0; up_i = 1'b0; pre_i = 1'b1; is_load_i = 1'b1;
    s_bit_i = 1'b0; wb_i = 1'b1; base_idx_i = 4'd5; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 done", {31'd0, done_o}, 32'd1);
    chk("R9 no access", {31'd0, bus_valid_o}, 32'd0);
    chk("R9 wb_en", {31'd0, wb_en_o}, 32'd1);
    chk("R9 wb_val", wb_val_o, 32'h1000);
    @(negedge clk);
    chk("R9 idle", {31'd0, busy_o}, 32'd0);

    // R7 no program-counter pulse on a store that lists register 15
    run_op('{16'h8000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 32'h1000, 32'h1004, 1'b0, 1'b0},
           -1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule